// File: doc/BRIEF.md
# Cumulative-Boundary Raster Timing Generator

This block produces the raster timing for a parallel RGB panel. It drives horizontal sync, vertical sync, data enable, a pixel-clock inversion select and a one-cycle line event. It also presents the current pixel column and line as counters. All outputs are referenced to the pixel clock that runs the block.

Timing is not programmed as separate porch lengths. Each axis is described by four running boundaries: the last sync position, the last back-porch position, the last active position and the last position of the line or frame. Each boundary adds its own interval to the one before it. Software writes four packed words that carry these boundaries, with the horizontal boundary in the upper half of each word and the vertical boundary in the lower half. It also writes a control word that holds the enable and four polarity selects, and a word that holds the line number at which the line event fires. Writing that line number as the last active line plus one makes the event mark the start of vertical blanking.

Internally, a run/off state machine gates two axis state machines. Each axis state machine has five states. IDLE is held while the block is off. From IDLE an axis enters SYNC once the block starts running. SYNC moves to BACK past the sync boundary. BACK moves to ACTIVE past the back-porch boundary. ACTIVE moves to FRONT past the active boundary. From FRONT, or from any state at the total boundary, the axis wraps back to SYNC. Every state returns to IDLE when the enable is cleared. The run/off machine moves from OFF to RUN one clock after the enable bit is written as 1, and from RUN back to OFF one clock after it is written as 0.

Top module: `raster_timing_gen`

## Requirements
- R1: The column counter starts at 0 and counts up by one each clock. After the clock in which it equals the total-width boundary (or exceeds it), it returns to 0. The total-width boundary must be at least 1.
- R2: The line counter advances by one on each clock in which the column counter returns to 0. After the line equal to the total-height boundary, it returns to 0.
- R3: Horizontal sync is active while column ≤ the sync-width boundary. Vertical sync is active for every clock of each line whose number is ≤ the sync-height boundary.
- R4: Data enable is active only when the column is above the back-porch boundary and at most the active-width boundary, and the line is above the vertical back-porch boundary and at most the active-height boundary.
- R5: Control word bit 31 selects horizontal sync polarity, bit 30 vertical sync polarity and bit 29 data-enable polarity. A 1 means active high and a 0 means active low. Bit 28 is presented directly on the pixel-clock inversion output.
- R6: Control word bit 0 enables the block. One clock after it is written as 1, both counters read 0 with timing running. One clock after it is written as 0, both counters are 0, all three timing signals sit at their inactive levels and the line event is low. They stay that way while the block is disabled.
- R7: The line event is high for exactly one clock, when the column is 0 and the line equals the programmed event line, and only while the block runs.
- R8: Write addresses: 0 is control, 1 is sync, 2 is back porch, 3 is active, 4 is total and 5 is the event line. In words 1 to 4 the horizontal boundary sits in bits [27:16] (12 bits) and the vertical boundary in bits [10:0] (11 bits). The event line sits in bits [10:0] of word 5. A write takes effect on the clock edge on which it is presented.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 3 | Configuration word select |
| cfg_wdata | input | 32 | Configuration write data |
| hsync_o | output | 1 | Horizontal sync, polarity per control bit 31 |
| vsync_o | output | 1 | Vertical sync, polarity per control bit 30 |
| de_o | output | 1 | Data enable, polarity per control bit 29 |
| pclk_inv_o | output | 1 | Pixel-clock inversion select, control bit 28 |
| line_evt_o | output | 1 | One-clock line event |
| pos_x_o | output | 12 | Current column |
| pos_y_o | output | 11 | Current line |

## Verification
Counters and phase states are registered. The sync, data-enable and event outputs are decoded from those registers without further delay, so every output is due in the clock after the edge that moved the counters. An enable written at edge k therefore shows column 0, line 0 after edge k+1, and a disable written at edge d shows the idle levels after edge d+1. The bench presents each write one edge ahead, then samples at falling edges. It walks whole frames pixel by pixel against a column and line model of its own, comparing every output in each sampled clock with values computed from the programmed boundaries.

// File: rtl/raster_pkg.sv
package raster_pkg;

    // Per-axis position phase
    typedef enum logic [2:0] {
        PH_IDLE,
        PH_SYNC,
        PH_BACK,
        PH_ACTIVE,
        PH_FRONT
    } phase_e;

    // Global run state
    typedef enum logic {
        RS_OFF,
        RS_RUN
    } run_e;

    localparam int unsigned ADDR_CTRL  = 0;
    localparam int unsigned ADDR_SYNC  = 1;
    localparam int unsigned ADDR_BACK  = 2;
    localparam int unsigned ADDR_ACT   = 3;
    localparam int unsigned ADDR_TOTAL = 4;
    localparam int unsigned ADDR_LINE  = 5;

    localparam int unsigned HFIELD_LSB = 16;
    localparam int unsigned VFIELD_LSB = 0;

    localparam int unsigned CTRL_EN_BIT  = 0;
    localparam int unsigned CTRL_PCK_BIT = 28;
    localparam int unsigned CTRL_DE_BIT  = 29;
    localparam int unsigned CTRL_VS_BIT  = 30;
    localparam int unsigned CTRL_HS_BIT  = 31;

endpackage

// File: rtl/raster_cfg_regs.sv
module raster_cfg_regs
    import raster_pkg::*;
#(
    parameter int unsigned HW = 12,
    parameter int unsigned VW = 11,
    parameter int unsigned DW = 32,
    parameter int unsigned AW = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    output logic          en,
    output logic          pol_hs,
    output logic          pol_vs,
    output logic          pol_de,
    output logic          pol_pck,
    output logic [HW-1:0] h_sync,
    output logic [HW-1:0] h_back,
    output logic [HW-1:0] h_act,
    output logic [HW-1:0] h_tot,
    output logic [VW-1:0] v_sync,
    output logic [VW-1:0] v_back,
    output logic [VW-1:0] v_act,
    output logic [VW-1:0] v_tot,
    output logic [VW-1:0] v_evt
);

    logic [HW-1:0] hf;
    logic [VW-1:0] vf;

    assign hf = wdata[HFIELD_LSB +: HW];
    assign vf = wdata[VFIELD_LSB +: VW];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en      <= 1'b0;
            pol_hs  <= 1'b0;
            pol_vs  <= 1'b0;
            pol_de  <= 1'b0;
            pol_pck <= 1'b0;
            h_sync  <= '0;
            h_back  <= '0;
            h_act   <= '0;
            h_tot   <= HW'(1);
            v_sync  <= '0;
            v_back  <= '0;
            v_act   <= '0;
            v_tot   <= '0;
            v_evt   <= '0;
        end else if (we) begin
            case (int'(addr))
                ADDR_CTRL: begin
                    en      <= wdata[CTRL_EN_BIT];
                    pol_hs  <= wdata[CTRL_HS_BIT];
                    pol_vs  <= wdata[CTRL_VS_BIT];
                    pol_de  <= wdata[CTRL_DE_BIT];
                    pol_pck <= wdata[CTRL_PCK_BIT];
                end
                ADDR_SYNC:  begin h_sync <= hf; v_sync <= vf; end
                ADDR_BACK:  begin h_back <= hf; v_back <= vf; end
                ADDR_ACT:   begin h_act  <= hf; v_act  <= vf; end
                ADDR_TOTAL: begin h_tot  <= hf; v_tot  <= vf; end
                ADDR_LINE:  v_evt <= vf;
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/raster_axis.sv
module raster_axis
    import raster_pkg::*;
#(
    parameter int unsigned W = 12
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         run_q,
    input  logic         run_d,
    input  logic         step,
    input  logic [W-1:0] lim_sync,
    input  logic [W-1:0] lim_back,
    input  logic [W-1:0] lim_act,
    input  logic [W-1:0] lim_tot,
    output logic [W-1:0] cnt_o,
    output logic         sync_o,
    output logic         act_o,
    output logic         wrap_o
);

    logic [W-1:0] cnt_q, cnt_d;
    phase_e       phase_q, phase_d;

    assign wrap_o = run_q && step && (cnt_q >= lim_tot);
    assign cnt_o  = cnt_q;

    // Next count
    always_comb begin
        if (!run_d)
            cnt_d = '0;
        else if (run_q && step)
            cnt_d = (cnt_q >= lim_tot) ? '0 : cnt_q + 1'b1;
        else
            cnt_d = cnt_q;
    end

    // Next phase follows the position the counter moves to
    always_comb begin
        if (!run_d)                 phase_d = PH_IDLE;
        else if (cnt_d <= lim_sync) phase_d = PH_SYNC;
        else if (cnt_d <= lim_back) phase_d = PH_BACK;
        else if (cnt_d <= lim_act)  phase_d = PH_ACTIVE;
        else                        phase_d = PH_FRONT;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q   <= '0;
            phase_q <= PH_IDLE;
        end else begin
            cnt_q   <= cnt_d;
            phase_q <= phase_d;
        end
    end

    always_comb begin
        sync_o = 1'b0;
        act_o  = 1'b0;
        unique case (phase_q)
            PH_IDLE:   ;
            PH_SYNC:   sync_o = 1'b1;
            PH_BACK:   ;
            PH_ACTIVE: act_o  = 1'b1;
            PH_FRONT:  ;
            default:   ;
        endcase
    end

    assert_wrap_R1_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (run_q && run_d && step && cnt_q >= lim_tot) |=> (cnt_q == '0));

    assert_step_R1_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (run_q && run_d && step && cnt_q < lim_tot) |=> (cnt_q == $past(cnt_q) + 1'b1));

    assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (run_q && run_d && !step) |=> $stable(cnt_q));

    assert_idle_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !run_q |-> (cnt_q == '0));

endmodule

// File: rtl/raster_timing_gen.sv
module raster_timing_gen
    import raster_pkg::*;
#(
    parameter int unsigned HW = 12,
    parameter int unsigned VW = 11,
    parameter int unsigned DW = 32,
    parameter int unsigned AW = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_we,
    input  logic [AW-1:0] cfg_addr,
    input  logic [DW-1:0] cfg_wdata,
    output logic          hsync_o,
    output logic          vsync_o,
    output logic          de_o,
    output logic          pclk_inv_o,
    output logic          line_evt_o,
    output logic [HW-1:0] pos_x_o,
    output logic [VW-1:0] pos_y_o
);

    logic          en, pol_hs, pol_vs, pol_de, pol_pck;
    logic [HW-1:0] h_sync, h_back, h_act, h_tot;
    logic [VW-1:0] v_sync, v_back, v_act, v_tot, v_evt;

    raster_cfg_regs #(.HW(HW), .VW(VW), .DW(DW), .AW(AW)) u_cfg (
        .clk    (clk),
        .rst_n  (rst_n),
        .we     (cfg_we),
        .addr   (cfg_addr),
        .wdata  (cfg_wdata),
        .en     (en),
        .pol_hs (pol_hs),
        .pol_vs (pol_vs),
        .pol_de (pol_de),
        .pol_pck(pol_pck),
        .h_sync (h_sync),
        .h_back (h_back),
        .h_act  (h_act),
        .h_tot  (h_tot),
        .v_sync (v_sync),
        .v_back (v_back),
        .v_act  (v_act),
        .v_tot  (v_tot),
        .v_evt  (v_evt)
    );

    run_e run_q, run_d;
    logic run_now, run_nxt;

    always_comb run_d = en ? RS_RUN : RS_OFF;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) run_q <= RS_OFF;
        else        run_q <= run_d;
    end

    assign run_now = (run_q == RS_RUN);
    assign run_nxt = (run_d == RS_RUN);

    logic          h_sync_on, h_act_on, h_wrap;
    logic          v_sync_on, v_act_on, v_wrap;
    logic [HW-1:0] h_cnt;
    logic [VW-1:0] v_cnt;

    raster_axis #(.W(HW)) u_hax (
        .clk     (clk),
        .rst_n   (rst_n),
        .run_q   (run_now),
        .run_d   (run_nxt),
        .step    (1'b1),
        .lim_sync(h_sync),
        .lim_back(h_back),
        .lim_act (h_act),
        .lim_tot (h_tot),
        .cnt_o   (h_cnt),
        .sync_o  (h_sync_on),
        .act_o   (h_act_on),
        .wrap_o  (h_wrap)
    );

    raster_axis #(.W(VW)) u_vax (
        .clk     (clk),
        .rst_n   (rst_n),
        .run_q   (run_now),
        .run_d   (run_nxt),
        .step    (h_wrap),
        .lim_sync(v_sync),
        .lim_back(v_back),
        .lim_act (v_act),
        .lim_tot (v_tot),
        .cnt_o   (v_cnt),
        .sync_o  (v_sync_on),
        .act_o   (v_act_on),
        .wrap_o  (v_wrap)
    );

    logic v_wrap_unused;
    assign v_wrap_unused = v_wrap;

    // Output decode per run state
    always_comb begin
        hsync_o    = ~pol_hs;
        vsync_o    = ~pol_vs;
        de_o       = ~pol_de;
        line_evt_o = 1'b0;
        unique case (run_q)
            RS_OFF: ;
            RS_RUN: begin
                hsync_o    = h_sync_on ? pol_hs : ~pol_hs;
                vsync_o    = v_sync_on ? pol_vs : ~pol_vs;
                de_o       = (h_act_on && v_act_on) ? pol_de : ~pol_de;
                line_evt_o = (h_cnt == '0) && (v_cnt == v_evt);
            end
            default: ;
        endcase
    end

    assign pclk_inv_o = pol_pck;
    assign pos_x_o    = h_cnt;
    assign pos_y_o    = v_cnt;

    assert_off_inactive_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (run_q == RS_OFF) |-> (hsync_o == ~pol_hs && vsync_o == ~pol_vs &&
                               de_o == ~pol_de && !line_evt_o &&
                               pos_x_o == '0 && pos_y_o == '0));

    assert_evt_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (line_evt_o && h_tot != '0) |=> !line_evt_o);

    assert_evt_at_col0_R7: assert property (@(posedge clk) disable iff (!rst_n)
        line_evt_o |-> (pos_x_o == '0 && run_q == RS_RUN));

endmodule

// File: tb/raster_timing_gen_tb.sv
module raster_timing_gen_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [2:0]  cfg_addr = '0;
    logic [31:0] cfg_wdata = '0;
    logic        hsync_o, vsync_o, de_o, pclk_inv_o, line_evt_o;
    logic [11:0] pos_x_o;
    logic [10:0] pos_y_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    raster_timing_gen u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .cfg_addr  (cfg_addr),
        .cfg_wdata (cfg_wdata),
        .hsync_o   (hsync_o),
        .vsync_o   (vsync_o),
        .de_o      (de_o),
        .pclk_inv_o(pclk_inv_o),
        .line_evt_o(line_evt_o),
        .pos_x_o   (pos_x_o),
        .pos_y_o   (pos_y_o)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic wr(input int a, input logic [31:0] d);
        @(negedge clk);
        cfg_we    = 1'b1;
        cfg_addr  = 3'(a);
        cfg_wdata = d;
        @(negedge clk);
        cfg_we    = 1'b0;
    endtask

    function automatic logic [31:0] pk(input int h, input int v);
        return (32'(h) << 16) | 32'(v);
    endfunction

    // Program boundaries, enable with polarities, sweep frames (R8 layout)
    task automatic run_frames(input int hs, hb, ha, ht, vs, vb, va, vt, evl,
                              input logic [3:0] pol, input int nfr);
        logic [31:0] ctrl;
        wr(1, pk(hs, vs));
        wr(2, pk(hb, vb));
        wr(3, pk(ha, va));
        wr(4, pk(ht, vt));
        wr(5, 32'(evl));
        ctrl = {pol, 27'd0, 1'b1};
        wr(0, ctrl);
        @(negedge clk);
        for (int f = 0; f < nfr; f++) begin
            for (int y = 0; y <= vt; y++) begin
                for (int x = 0; x <= ht; x++) begin
                    bit hact, vact, dact;
                    hact = (x <= hs);
                    vact = (y <= vs);
                    dact = (x > hb) && (x <= ha) && (y > vb) && (y <= va);
                    chk("R1", "pos_x", int'(pos_x_o), x);
                    chk("R2", "pos_y", int'(pos_y_o), y);
                    chk("R3", "hsync", int'(hsync_o), int'(hact ? pol[3] : !pol[3]));
                    chk("R3", "vsync", int'(vsync_o), int'(vact ? pol[2] : !pol[2]));
                    chk("R4", "de", int'(de_o), int'(dact ? pol[1] : !pol[1]));
                    chk("R5", "pclk_inv", int'(pclk_inv_o), int'(pol[0]));
                    chk("R7", "line_evt", int'(line_evt_o), int'(x == 0 && y == evl));
                    @(negedge clk);
                end
            end
        end
    endtask

    task automatic check_off(input logic [3:0] pol, input int ncyc);
        for (int i = 0; i < ncyc; i++) begin
            chk("R6", "off pos_x", int'(pos_x_o), 0);
            chk("R6", "off pos_y", int'(pos_y_o), 0);
            chk("R6", "off hsync", int'(hsync_o), int'(!pol[3]));
            chk("R6", "off vsync", int'(vsync_o), int'(!pol[2]));
            chk("R6", "off de", int'(de_o), int'(!pol[1]));
            chk("R6", "off line_evt", int'(line_evt_o), 0);
            @(negedge clk);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // Reset state: disabled, all polarities active low
        check_off(4'b0000, 3);
        chk("R5", "reset pclk_inv", int'(pclk_inv_o), 0);

        // Config A, active-low everything, event at start of vertical blanking
        run_frames(1, 3, 7, 9, 0, 2, 5, 6, 6, 4'b0000, 2);

        // Disable: idle one clock after the write (R6)
        wr(0, 32'h0);
        @(negedge clk);
        check_off(4'b0000, 5);

        // Config B, all polarities high, event on an early line
        run_frames(0, 2, 5, 6, 1, 2, 4, 5, 2, 4'b1111, 2);

        // Disable while keeping polarities high (R6, R5)
        wr(0, 32'hF000_0000);
        @(negedge clk);
        check_off(4'b1111, 4);
        chk("R5", "pclk_inv held", int'(pclk_inv_o), 1);

        // Mixed polarity, event line in the active area; R8 field packing reused
        run_frames(2, 4, 9, 11, 1, 1, 3, 4, 3, 4'b1010, 1);

        done = 1'b1;
    end

    initial begin
        for (int i = 0; i < 100000; i++) begin
            @(posedge clk);
            if (done) break;
        end
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog run did not finish actual=0 expected=1");
        end
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule